// File: doc/BRIEF.md
# Store Queue with In-Order Cache Writeback

This block keeps stores in a circular buffer from dispatch until their data has reached the data cache. Stores enter at the tail in program order. Each store carries a sequence number, an address, data and a byte size. The commit stage reports the youngest committed sequence number. Every committed store then becomes eligible for writeback.

Eligible stores go to the cache in order from a separate writeback pointer, at most one request per cycle, over a valid/ready port. The cache acknowledges each write by queue index, and these acknowledgements may arrive in any order. The head pointer moves only across an unbroken run of completed entries, so slots are released in order.

A squash removes younger, uncommitted stores from the tail. A load that waits on one particular store can register a stall. When that store is issued or completed, the block returns the load's index as a replay request. Upstream logic uses the reported free-entry count for flow control.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty (`sq_count` = 0, `wb_pending` = 0), no write is requested, and the first allocation index is 0.
- R2: An allocation goes to slot `alloc_idx`, which is the tail. The tail wraps from DEPTH back to 0, because there are DEPTH+1 slots. An allocation is ignored when `sq_count` equals DEPTH, and also in any cycle that has a squash.
- R3: A commit with sequence number C scans from the head. Each non-eligible store with sequence number ≤ C becomes eligible and adds one to `wb_pending`. The scan stops at the first non-eligible store whose sequence number is greater than C.
- R4: Write requests leave in queue order from the writeback pointer, at most one per cycle. A request is raised only when `wb_pending` is non-zero and the entry at the pointer is eligible. It is accepted on a cycle where `wr_valid` and `wr_ready` are both high.
- R5: An eligible store of size 0 raises no request. It completes in the cycle it reaches the writeback pointer: `wb_pending` drops by one and the pointer moves on.
- R6: If `wr_valid` is high while `wr_ready` is low, the block becomes blocked. `wr_valid` stays low until a cycle with `wr_ready` high clears the block. The same store (same `wr_idx`) is then requested again.
- R7: An acknowledgement names a slot through `ack_idx`, marks that slot complete and lowers `wb_pending` by one. The head, and with it `sq_count`, moves only across a contiguous run of completed entries that starts at the head.
- R8: A squash with sequence number S removes stores backward from the tail while their sequence number is greater than S. It stops at the first eligible store, which is never removed.
- R9: After a stall registered on store sequence number Q with load index L, `replay_valid` pulses for one cycle, with `replay_load_idx` = L, in the cycle after store Q is accepted by the cache or completes.
- R10: `free_entries` equals min(`lq_slots_free`, DEPTH+1 − `sq_count`) − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data |
| alloc_size | input | SIZE_W | Store size in bytes; 0 means no cache access |
| alloc_idx | output | IW | Slot index the next allocation takes |
| commit_valid | input | 1 | Commit notification |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| wr_valid | output | 1 | Cache write request |
| wr_ready | input | 1 | Cache accepts the request |
| wr_idx | output | IW | Queue slot of the request |
| wr_addr | output | ADDR_W | Request address |
| wr_data | output | DATA_W | Request data |
| wr_size | output | SIZE_W | Request size |
| ack_valid | input | 1 | Write completion |
| ack_idx | input | IW | Slot that completed |
| stall_valid | input | 1 | Register a load stalled on a store |
| stall_seq | input | SEQ_W | Sequence number of the blocking store |
| stall_load_idx | input | LDX_W | Load queue index of the stalled load |
| replay_valid | output | 1 | Replay request for the stalled load |
| replay_load_idx | output | LDX_W | Load index to replay |
| lq_slots_free | input | LQ_W | Free load queue slots, including its reserved slot |
| free_entries | output | CW | Entries available to dispatch |
| sq_count | output | CW | Stores held |
| wb_pending | output | CW | Eligible stores not yet completed |

## Verification
The assertions rely on well-formed inputs:
- Each issued store is acknowledged exactly once, and only its own slot is acknowledged.
- Sequence numbers increase in allocation order and never wrap within a run.
- A squash never names a sequence number older than the last commit.
- A stall names a store that is present in the queue.

The stimulus respects these rules by construction. It allocates with rising sequence numbers and acknowledges only slots it has seen accepted on the write port. It squashes only above the committed point, except for one deliberate case where the squash stops at an eligible store. It registers a stall only on a store that is queued.

// File: rtl/store_queue.sv
module store_queue #(
  parameter int DEPTH  = 4,
  parameter int SEQ_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4,
  parameter int LQ_W   = 4,
  parameter int LDX_W  = 4,
  localparam int SLOTS = DEPTH + 1,
  localparam int IW    = $clog2(SLOTS),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic [SIZE_W-1:0] alloc_size,
  output logic [IW-1:0]     alloc_idx,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [IW-1:0]     wr_idx,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [SIZE_W-1:0] wr_size,
  input  logic              ack_valid,
  input  logic [IW-1:0]     ack_idx,
  input  logic              stall_valid,
  input  logic [SEQ_W-1:0]  stall_seq,
  input  logic [LDX_W-1:0]  stall_load_idx,
  output logic              replay_valid,
  output logic [LDX_W-1:0]  replay_load_idx,
  input  logic [LQ_W-1:0]   lq_slots_free,
  output logic [CW-1:0]     free_entries,
  output logic [CW-1:0]     sq_count,
  output logic [CW-1:0]     wb_pending
);
  localparam int FW = ((LQ_W > IW) ? LQ_W : IW) + 1;

  logic [IW-1:0]     head, wb, tail;
  logic [CW-1:0]     count, pend;
  logic [SEQ_W-1:0]  seq_q  [SLOTS];
  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic [DATA_W-1:0] data_q [SLOTS];
  logic [SIZE_W-1:0] size_q [SLOTS];
  logic [SLOTS-1:0]  elig, done;
  logic              blocked;
  logic              stalled;
  logic [SEQ_W-1:0]  st_seq;
  logic [LDX_W-1:0]  st_ld;
  logic              replay_q;
  logic [LDX_W-1:0]  replay_idx_q;

  function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] a, input int b);
    int s;
    s = int'(a) + b;
    if (s >= SLOTS) s = s - SLOTS;
    if (s < 0) s = s + SLOTS;
    return s[IW-1:0];
  endfunction

  logic wb_open, zero_done, issue, alloc_ok, hit;
  assign wb_open   = (pend != '0) && (wb != tail) && elig[wb];
  assign zero_done = wb_open && (size_q[wb] == '0);
  assign wr_valid  = wb_open && !zero_done && !blocked;
  assign issue     = wr_valid && wr_ready;
  assign alloc_ok  = alloc_valid && !squash_valid && (count < CW'(DEPTH));

  assign wr_idx  = wb;
  assign wr_addr = addr_q[wb];
  assign wr_data = data_q[wb];
  assign wr_size = size_q[wb];
  assign alloc_idx  = tail;
  assign sq_count   = count;
  assign wb_pending = pend;
  assign replay_valid    = replay_q;
  assign replay_load_idx = replay_idx_q;

  logic [SLOTS-1:0] elig_n;
  logic [CW-1:0]    add_n;
  always_comb begin
    logic run;
    logic [IW-1:0] idx;
    elig_n = elig;
    add_n  = '0;
    run    = commit_valid;
    for (int k = 0; k < DEPTH; k++) begin
      idx = wrap_add(head, k);
      if (run && (k < int'(count)) && !elig[idx]) begin
        if (seq_q[idx] > commit_seq) run = 1'b0;
        else begin
          elig_n[idx] = 1'b1;
          add_n = add_n + CW'(1);
        end
      end
    end
  end

  logic [SLOTS-1:0] done_n, free_mask;
  logic [CW-1:0]    adv;
  always_comb begin
    logic run;
    logic [IW-1:0] idx;
    done_n = done;
    if (ack_valid) done_n[ack_idx] = 1'b1;
    if (zero_done) done_n[wb] = 1'b1;
    adv = '0;
    free_mask = '0;
    run = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      idx = wrap_add(head, k);
      if (run && (k < int'(count)) && done_n[idx]) begin
        adv = adv + CW'(1);
        free_mask[idx] = 1'b1;
      end else run = 1'b0;
    end
  end

  logic [CW-1:0] rm;
  always_comb begin
    logic run;
    logic [IW-1:0] idx;
    rm  = '0;
    run = squash_valid;
    for (int k = 0; k < DEPTH; k++) begin
      idx = wrap_add(tail, -(k + 1));
      if (run && (k < int'(count)) && !elig_n[idx] && (seq_q[idx] > squash_seq))
        rm = rm + CW'(1);
      else run = 1'b0;
    end
  end

  assign hit = stalled &&
               (((issue || zero_done) && (seq_q[wb] == st_seq)) ||
                (ack_valid && (seq_q[ack_idx] == st_seq)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      wb <= '0;
      tail <= '0;
      count <= '0;
      pend <= '0;
      elig <= '0;
      done <= '0;
      blocked <= 1'b0;
      stalled <= 1'b0;
      st_seq <= '0;
      st_ld <= '0;
      replay_q <= 1'b0;
      replay_idx_q <= '0;
    end else begin
      head  <= wrap_add(head, int'(adv));
      count <= count + CW'(alloc_ok) - adv - rm;
      pend  <= pend + add_n - CW'(ack_valid) - CW'(zero_done);
      if (squash_valid) tail <= wrap_add(tail, -int'(rm));
      else if (alloc_ok) tail <= wrap_add(tail, 1);
      if (issue || zero_done) wb <= wrap_add(wb, 1);
      elig <= elig_n & ~free_mask;
      done <= done_n & ~free_mask;
      if (wr_valid && !wr_ready) blocked <= 1'b1;
      else if (wr_ready) blocked <= 1'b0;
      replay_q <= hit;
      if (hit) begin
        replay_idx_q <= st_ld;
        stalled <= 1'b0;
      end else if (stall_valid) begin
        stalled <= 1'b1;
        st_seq <= stall_seq;
        st_ld <= stall_load_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_ok) begin
      seq_q[tail]  <= alloc_seq;
      addr_q[tail] <= alloc_addr;
      data_q[tail] <= alloc_data;
      size_q[tail] <= alloc_size;
    end
  end

  logic [FW-1:0] sq_free, lq_free, min_free;
  assign sq_free  = FW'(SLOTS) - FW'(count);
  assign lq_free  = FW'(lq_slots_free);
  assign min_free = (lq_free < sq_free) ? lq_free : sq_free;
  assign free_entries = CW'(min_free - FW'(1));

  a_r3_pending_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pending <= sq_count);
  a_r5_zero_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_size != '0);
  a_r6_refused_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (!wr_valid && $stable(wr_idx)));
  a_r8_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> sq_count <= $past(sq_count));
  a_r9_replay_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |=> !replay_valid);
endmodule

// File: tb/store_queue_test.sv
`timescale 1ns/1ps
module store_queue_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0;
  logic [7:0] alloc_seq = 0;
  logic [15:0] alloc_addr = 0;
  logic [31:0] alloc_data = 0;
  logic [3:0] alloc_size = 0;
  logic [2:0] alloc_idx;
  logic commit_valid = 0;
  logic [7:0] commit_seq = 0;
  logic squash_valid = 0;
  logic [7:0] squash_seq = 0;
  logic wr_valid;
  logic wr_ready = 1;
  logic [2:0] wr_idx;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0] wr_size;
  logic ack_valid = 0;
  logic [2:0] ack_idx = 0;
  logic stall_valid = 0;
  logic [7:0] stall_seq = 0;
  logic [3:0] stall_load_idx = 0;
  logic replay_valid;
  logic [3:0] replay_load_idx;
  logic [3:0] lq_slots_free = 4'd9;
  logic [2:0] free_entries, sq_count, wb_pending;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  store_queue uut (.*);

  localparam logic [27:0] VEC [4] = '{
    {8'd10, 16'h0100, 4'd4},
    {8'd11, 16'h0104, 4'd4},
    {8'd12, 16'h0108, 4'd2},
    {8'd13, 16'h010C, 4'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    alloc_valid = 0; commit_valid = 0; squash_valid = 0;
    ack_valid = 0; stall_valid = 0;
  endtask

  task automatic put(input logic [7:0] s, input logic [15:0] a, input logic [3:0] z);
    alloc_valid = 1; alloc_seq = s; alloc_addr = a; alloc_data = {16'hD0, a}; alloc_size = z;
  endtask

  task automatic ack(input logic [2:0] i);
    ack_valid = 1; ack_idx = i; step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    step(); step();
    rst_n = 1;
    chk(sq_count == 0, "R1", sq_count, 0);
    chk(wb_pending == 0, "R1", wb_pending, 0);
    chk(wr_valid == 0, "R1", wr_valid, 0);
    chk(alloc_idx == 0, "R1", alloc_idx, 0);
    chk(free_entries == 4, "R10", free_entries, 4);

    for (int i = 0; i < 4; i++) begin
      put(VEC[i][27:20], VEC[i][19:4], VEC[i][3:0]);
      chk(alloc_idx == 3'(i), "R2", alloc_idx, i);
      step();
    end
    chk(sq_count == 4, "R2", sq_count, 4);
    chk(free_entries == 0, "R10", free_entries, 0);
    put(8'd99, 16'h0999, 4'd4);
    step();
    chk(sq_count == 4, "R2 full ignore", sq_count, 4);

    commit_valid = 1; commit_seq = 8'd11; step();
    chk(wb_pending == 2, "R3", wb_pending, 2);
    chk(wr_valid && wr_addr == VEC[0][19:4], "R4", wr_addr, VEC[0][19:4]);
    step();
    chk(wr_valid && wr_addr == VEC[1][19:4], "R4", wr_addr, VEC[1][19:4]);
    step();
    chk(wr_valid == 0, "R4 stop at non-eligible", wr_valid, 0);
    ack(3'd1);
    chk(sq_count == 4, "R7 out-of-order ack holds head", sq_count, 4);
    chk(wb_pending == 1, "R7", wb_pending, 1);
    ack(3'd0);
    chk(sq_count == 2, "R7", sq_count, 2);

    put(8'd14, 16'h0200, 4'd0);
    chk(alloc_idx == 4, "R2", alloc_idx, 4);
    step();
    put(8'd15, 16'h0204, 4'd4);
    chk(alloc_idx == 0, "R2 wrap", alloc_idx, 0);
    step();
    commit_valid = 1; commit_seq = 8'd14; step();
    chk(wb_pending == 3, "R3", wb_pending, 3);
    chk(wr_valid && wr_addr == 16'h0108, "R4", wr_addr, 16'h0108);
    step();
    chk(wr_valid && wr_addr == 16'h010C, "R4", wr_addr, 16'h010C);
    step();
    chk(wr_valid == 0, "R5 no request", wr_valid, 0);
    step();
    chk(wb_pending == 2, "R5", wb_pending, 2);
    chk(sq_count == 4, "R7 not contiguous", sq_count, 4);
    chk(wr_valid == 0, "R3 stop at younger", wr_valid, 0);
    ack(3'd3);
    chk(sq_count == 4, "R7", sq_count, 4);
    ack(3'd2);
    chk(sq_count == 1, "R7 run skip", sq_count, 1);

    wr_ready = 0;
    put(8'd16, 16'h0300, 4'd4);
    step();
    commit_valid = 1; commit_seq = 8'd16; step();
    chk(wr_valid && wr_idx == 0, "R6", wr_idx, 0);
    step();
    chk(wr_valid == 0, "R6 blocked", wr_valid, 0);
    chk(wr_idx == 0, "R6 index held", wr_idx, 0);
    step();
    chk(wr_valid == 0, "R6 blocked", wr_valid, 0);
    wr_ready = 1;
    step();
    chk(wr_valid && wr_addr == 16'h0204, "R6 retry", wr_addr, 16'h0204);
    chk(wr_data == 32'h00D00204, "R6 data", wr_data, 32'h00D00204);
    step();
    chk(wr_valid && wr_addr == 16'h0300, "R4", wr_addr, 16'h0300);
    step();
    ack(3'd0);
    ack(3'd1);
    chk(sq_count == 0, "R7", sq_count, 0);

    put(8'd20, 16'h0400, 4'd4); step();
    put(8'd21, 16'h0404, 4'd4); step();
    put(8'd22, 16'h0408, 4'd4); step();
    commit_valid = 1; commit_seq = 8'd20; step();
    step();
    squash_valid = 1; squash_seq = 8'd20; step();
    chk(sq_count == 1, "R8", sq_count, 1);
    chk(alloc_idx == 3, "R8 tail", alloc_idx, 3);
    squash_valid = 1; squash_seq = 8'd5;
    put(8'd23, 16'h040C, 4'd4);
    step();
    chk(sq_count == 1, "R8 eligible kept", sq_count, 1);
    chk(alloc_idx == 3, "R2 squash blocks alloc", alloc_idx, 3);
    ack(3'd2);
    chk(sq_count == 0, "R7", sq_count, 0);

    put(8'd30, 16'h0500, 4'd4); step();
    stall_valid = 1; stall_seq = 8'd30; stall_load_idx = 4'd7; step();
    commit_valid = 1; commit_seq = 8'd30; step();
    chk(replay_valid == 0, "R9 early", replay_valid, 0);
    step();
    chk(replay_valid && replay_load_idx == 7, "R9 issue", replay_load_idx, 7);
    step();
    chk(replay_valid == 0, "R9 pulse", replay_valid, 0);
    ack(3'd3);
    put(8'd31, 16'h0600, 4'd0); step();
    stall_valid = 1; stall_seq = 8'd31; stall_load_idx = 4'd5; step();
    commit_valid = 1; commit_seq = 8'd31; step();
    chk(replay_valid == 0, "R9 early", replay_valid, 0);
    step();
    chk(replay_valid && replay_load_idx == 5, "R9 complete", replay_load_idx, 5);
    chk(sq_count == 0, "R5 zero-size frees", sq_count, 0);

    lq_slots_free = 4'd2;
    #1;
    chk(free_entries == 1, "R10 load side", free_entries, 1);
    finish_run();
  end
endmodule